// File: doc/BRIEF.md
# Word-Sync Serial Command Link

This block carries three kinds of lane-wide command over a single wire so that several receiving devices can add or drop IDLE words, or re-establish word alignment, on exactly the same word clock. One device is picked as the master. Its transmit side takes requests for a word sync event, an IDLE deletion or an IDLE insertion. It turns each accepted request into a three-bit serial frame, one bit per word clock. The line rests low when there is nothing to do.

Every device, the master included, runs the receive side. The receive side watches the line, recognises a frame by its leading 1 and decodes the two command bits that follow. It then raises a one-cycle strobe at a fixed distance from the start bit, so the same strobe fires on the same clock in every device. In the master the receive side listens to its own transmit output and ignores the external line input. In a non-master device it listens to the external line input, and its own transmitter stays silent.

The request side behaves as a valid/ready stream with a one-entry holding slot. A request is taken only on a cycle where `req_ready` is high. A request presented while `req_ready` is low is discarded rather than stalled, because the requester raises one-cycle events. No data ever waits at the block's edge.

Top module: `wsync_link`

## Requirements
- R1: After reset `line_out` is low, all three strobes are low and, in master mode, `req_ready` is high.
- R2: While no frame is being sent, `line_out` stays low.
- R3: A frame is a 1 followed by two command bits, most significant first: 01 for sync, 10 for delete, 11 for insert. When a request is accepted at clock edge E0 and the transmitter is free, the start bit appears on `line_out` after edge E1, and the two command bits follow after edges E2 and E3.
- R4: When several requests are raised in the same accepted cycle, only one is taken: sync wins over delete, and delete wins over insert. The others are discarded.
- R5: The block holds at most one pending request. `req_ready` is low from the edge that accepts a request until the edge that hands it to the transmitter. A request raised while `req_ready` is low is discarded.
- R6: The receive side raises exactly one one-cycle strobe (`ev_sync`, `ev_del` or `ev_ins`) in the cycle right after the third bit of a frame. That is three cycles after the start bit first appears on its line, and four cycles after a master accepts the request.
- R7: A start bit followed by 00 produces no strobe, and the receiver returns to hunting for a start bit.
- R8: With `is_master` high the receiver takes `line_out` and ignores `line_in`. With `is_master` low it takes `line_in`, `line_out` stays low, `req_ready` is low and requests are ignored.
- R9: Frames may follow each other with no idle gap: a pending request starts the cycle after the previous frame's last bit, and both frames are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock of the master lane |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | High selects master role and loopback |
| req_sync | input | 1 | Request: word sync event seen |
| req_del | input | 1 | Request: delete next IDLE |
| req_ins | input | 1 | Request: insert an IDLE after the next IDLE |
| req_ready | output | 1 | Holding slot empty, requests accepted |
| line_in | input | 1 | Serial command line from the master device |
| line_out | output | 1 | Serial command line driven by this device |
| ev_sync | output | 1 | One-cycle strobe: sync frame decoded |
| ev_del | output | 1 | One-cycle strobe: delete frame decoded |
| ev_ins | output | 1 | One-cycle strobe: insert frame decoded |

## Verification
A corrupted bit counter in the transmitter shows up on `line_out` within the frame it hits, as a missing or extra bit. The loss of frame boundaries that follows gives a wrong strobe or no strobe four cycles after acceptance. A stuck or lost holding slot shows on `req_ready` one cycle after the request, and as a missing second frame in a back-to-back pair. A receiver that mis-counts bits fires its strobe on the wrong cycle or on the wrong line. So each strobe is checked both on its exact cycle and against the three line bits that came before it.

// File: rtl/wsl_pkg.sv
package wsl_pkg;
  // number of command bits after the start bit
  localparam int CMD_W = 2;
  localparam int CNT_W = $clog2(CMD_W + 1);

  // on-wire command field values
  typedef enum logic [CMD_W-1:0] {
    CMD_NONE = 2'b00,
    CMD_SYNC = 2'b01,
    CMD_DEL  = 2'b10,
    CMD_INS  = 2'b11
  } wsl_cmd_e;
endpackage

// File: rtl/wsl_req_slot.sv
module wsl_req_slot
  import wsl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     is_master,
  input  logic     req_sync,
  input  logic     req_del,
  input  logic     req_ins,
  input  logic     take,
  output logic     req_ready,
  output logic     slot_valid,
  output wsl_cmd_e slot_cmd
);
  wsl_cmd_e pick;
  logic     any_req;

  // fixed priority: sync over delete over insert
  always_comb begin
    if (req_sync)     pick = CMD_SYNC;
    else if (req_del) pick = CMD_DEL;
    else if (req_ins) pick = CMD_INS;
    else              pick = CMD_NONE;
  end

  assign any_req   = req_sync | req_del | req_ins;
  assign req_ready = is_master & ~slot_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_valid <= 1'b0;
      slot_cmd   <= CMD_NONE;
    end else if (req_ready && any_req) begin
      slot_valid <= 1'b1;
      slot_cmd   <= pick;
    end else if (take) begin
      slot_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wsl_tx_ser.sv
module wsl_tx_ser
  import wsl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     is_master,
  input  logic     slot_valid,
  input  wsl_cmd_e slot_cmd,
  output logic     take,
  output logic     tx_line
);
  logic [CMD_W-1:0] sh_q;
  logic [CNT_W-1:0] left_q;
  logic             idle;

  assign idle = (left_q == '0);
  assign take = idle & slot_valid & is_master;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      left_q  <= '0;
      tx_line <= 1'b0;
    end else if (take) begin
      tx_line <= 1'b1;
      sh_q    <= slot_cmd;
      left_q  <= CNT_W'(CMD_W);
    end else if (!idle) begin
      tx_line <= sh_q[CMD_W-1];
      sh_q    <= sh_q << 1;
      left_q  <= left_q - 1'b1;
    end else begin
      tx_line <= 1'b0;
    end
  end
endmodule

// File: rtl/wsl_rx_dec.sv
module wsl_rx_dec
  import wsl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  output logic ev_sync,
  output logic ev_del,
  output logic ev_ins
);
  logic [CMD_W-2:0] sh_q;
  logic [CNT_W-1:0] need_q;
  logic [CMD_W-1:0] full;

  assign full = {sh_q, rx_line};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      need_q  <= '0;
      ev_sync <= 1'b0;
      ev_del  <= 1'b0;
      ev_ins  <= 1'b0;
    end else begin
      ev_sync <= 1'b0;
      ev_del  <= 1'b0;
      ev_ins  <= 1'b0;
      if (need_q == '0) begin
        if (rx_line) need_q <= CNT_W'(CMD_W);
      end else begin
        sh_q   <= full[CMD_W-2:0];
        need_q <= need_q - 1'b1;
        if (need_q == CNT_W'(1)) begin
          ev_sync <= (full == CMD_SYNC);
          ev_del  <= (full == CMD_DEL);
          ev_ins  <= (full == CMD_INS);
        end
      end
    end
  end
endmodule

// File: rtl/wsync_link.sv
module wsync_link
  import wsl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic is_master,
  input  logic req_sync,
  input  logic req_del,
  input  logic req_ins,
  output logic req_ready,
  input  logic line_in,
  output logic line_out,
  output logic ev_sync,
  output logic ev_del,
  output logic ev_ins
);
  logic     slot_valid;
  wsl_cmd_e slot_cmd;
  logic     take;
  logic     tx_line;
  logic     rx_line;

  wsl_req_slot u_slot (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .req_sync(req_sync), .req_del(req_del), .req_ins(req_ins),
    .take(take), .req_ready(req_ready),
    .slot_valid(slot_valid), .slot_cmd(slot_cmd)
  );

  wsl_tx_ser u_tx (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .slot_valid(slot_valid), .slot_cmd(slot_cmd),
    .take(take), .tx_line(tx_line)
  );

  assign line_out = is_master & tx_line;
  assign rx_line  = is_master ? line_out : line_in;

  wsl_rx_dec u_rx (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
    .ev_sync(ev_sync), .ev_del(ev_del), .ev_ins(ev_ins)
  );
endmodule

// File: rtl/wsync_link_chk.sv
module wsync_link_chk (
  input logic clk,
  input logic rst_n,
  input logic is_master,
  input logic req_sync,
  input logic req_del,
  input logic req_ins,
  input logic req_ready,
  input logic line_in,
  input logic line_out,
  input logic ev_sync,
  input logic ev_del,
  input logic ev_ins
);
  logic seen;
  logic any_req;
  assign seen    = is_master ? line_out : line_in;
  assign any_req = req_sync | req_del | req_ins;

  AST_SLAVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> !line_out); // R8
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_sync, ev_del, ev_ins})); // R6
  AST_SYNC_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync |-> ($past(seen, 3) && !$past(seen, 2) && $past(seen, 1))); // R3
  AST_DEL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ev_del |-> ($past(seen, 3) && $past(seen, 2) && !$past(seen, 1))); // R3
  AST_INS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ins |-> ($past(seen, 3) && $past(seen, 2) && $past(seen, 1))); // R3
  AST_SLOT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && any_req) |=> !req_ready); // R5
endmodule

bind wsync_link wsync_link_chk u_chk (
  .clk(clk), .rst_n(rst_n), .is_master(is_master),
  .req_sync(req_sync), .req_del(req_del), .req_ins(req_ins),
  .req_ready(req_ready), .line_in(line_in), .line_out(line_out),
  .ev_sync(ev_sync), .ev_del(ev_del), .ev_ins(ev_ins)
);

// File: tb/wsync_link_tb.sv
module wsync_link_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master = 1'b1;
  logic req_sync = 1'b0, req_del = 1'b0, req_ins = 1'b0;
  logic line_in = 1'b0;
  logic req_ready, line_out, ev_sync, ev_del, ev_ins;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  wsync_link u_dut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .req_sync(req_sync), .req_del(req_del), .req_ins(req_ins),
    .req_ready(req_ready), .line_in(line_in), .line_out(line_out),
    .ev_sync(ev_sync), .ev_del(ev_del), .ev_ins(ev_ins)
  );

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2:0] evs();
    return {ev_sync, ev_del, ev_ins};
  endfunction

  task automatic t_reset();
    chk({3'b0, line_out}, 4'd0, "R1 line_out after reset");
    chk({1'b0, evs()}, 4'd0, "R1 strobes after reset");
    chk({3'b0, req_ready}, 4'd1, "R1 req_ready after reset");
    step();
    chk({3'b0, line_out}, 4'd0, "R2 line idle low");
  endtask

  // cmd: 1 sync, 2 del, 3 ins ; exp strobe vector
  task automatic t_frame(input logic [1:0] cmd, input logic [2:0] exp_ev, input string tag);
    req_sync = (cmd == 2'd1); req_del = (cmd == 2'd2); req_ins = (cmd == 2'd3);
    step(); // E0
    req_sync = 0; req_del = 0; req_ins = 0;
    chk({3'b0, req_ready}, 4'd0, {"R5 ready low after accept ", tag});
    chk({3'b0, line_out}, 4'd0, {"R2 line low before start ", tag});
    step(); // E1
    chk({3'b0, line_out}, 4'd1, {"R3 start bit ", tag});
    chk({3'b0, req_ready}, 4'd1, {"R5 ready back ", tag});
    step(); // E2
    chk({3'b0, line_out}, {3'b0, cmd[1]}, {"R3 first cmd bit ", tag});
    step(); // E3
    chk({3'b0, line_out}, {3'b0, cmd[0]}, {"R3 second cmd bit ", tag});
    chk({1'b0, evs()}, 4'd0, {"R6 no early strobe ", tag});
    step(); // E4
    chk({1'b0, evs()}, {1'b0, exp_ev}, {"R6 strobe on time R8 loopback ", tag});
    chk({3'b0, line_out}, 4'd0, {"R2 line low after frame ", tag});
    step(); // E5
    chk({1'b0, evs()}, 4'd0, {"R6 strobe one cycle ", tag});
  endtask

  task automatic t_priority();
    logic [2:0] acc = 3'b0;
    req_sync = 1; req_del = 1; req_ins = 1;
    step();
    req_sync = 0; req_del = 0; req_ins = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      acc = acc | evs();
    end
    chk({1'b0, acc}, 4'b0100, "R4 all three raised, only sync");
    req_del = 1; req_ins = 1;
    step();
    req_del = 0; req_ins = 0;
    acc = 3'b0;
    for (int i = 0; i < 10; i++) begin
      step();
      acc = acc | evs();
    end
    chk({1'b0, acc}, 4'b0010, "R4 delete beats insert");
  endtask

  task automatic t_pending();
    int n_ins = 0;
    req_del = 1;
    step(); // E0
    req_del = 0;
    chk({3'b0, req_ready}, 4'd0, "R5 slot full");
    req_ins = 1; // dropped
    step(); // E1
    req_ins = 0;
    chk({3'b0, req_ready}, 4'd1, "R5 slot handed over");
    req_sync = 1; // held while del frame runs
    step(); // E2
    req_sync = 0;
    chk({3'b0, req_ready}, 4'd0, "R5 pending held");
    step(); // E3
    chk({3'b0, req_ready}, 4'd0, "R5 still pending");
    step(); // E4
    chk({1'b0, evs()}, 4'b0010, "R9 first frame strobe");
    chk({3'b0, line_out}, 4'd1, "R9 next start with no gap");
    chk({3'b0, req_ready}, 4'd1, "R5 ready after handoff");
    step(); // E5
    chk({3'b0, line_out}, 4'd0, "R9 second frame bit1");
    step(); // E6
    chk({3'b0, line_out}, 4'd1, "R9 second frame bit0");
    step(); // E7
    chk({1'b0, evs()}, 4'b0100, "R9 second frame strobe");
    for (int i = 0; i < 8; i++) begin
      step();
      if (ev_ins) n_ins++;
    end
    chk(4'(n_ins), 4'd0, "R5 request while not ready discarded");
  endtask

  task automatic send_ext(input logic [2:0] bits);
    for (int i = 2; i >= 0; i--) begin
      line_in = bits[i];
      step();
    end
    line_in = 0;
  endtask

  task automatic t_slave();
    logic [2:0] acc = 3'b0;
    is_master = 0;
    step();
    chk({3'b0, req_ready}, 4'd0, "R8 slave ready low");
    req_sync = 1;
    step();
    req_sync = 0;
    for (int i = 0; i < 6; i++) begin
      step();
      if (line_out) acc[0] = 1;
      acc[1] = acc[1] | (|evs());
    end
    chk({2'b0, acc[1:0]}, 4'd0, "R8 slave ignores requests");
    send_ext(3'b111); // start bit sampled first; strobe after third bit
    chk({1'b0, evs()}, 4'b0001, "R6 external insert strobe");
    step();
    chk({1'b0, evs()}, 4'd0, "R6 external strobe one cycle");
    send_ext(3'b100);
    acc = 3'b0;
    for (int i = 0; i < 4; i++) begin
      acc = acc | evs();
      step();
    end
    chk({1'b0, acc}, 4'd0, "R7 code 00 gives no strobe");
    send_ext(3'b110);
    chk({1'b0, evs()}, 4'b0010, "R7 hunting resumed, delete decoded");
    is_master = 1;
    step();
    acc = 3'b0;
    line_in = 1;
    for (int i = 0; i < 6; i++) begin
      step();
      acc = acc | evs();
    end
    line_in = 0;
    chk({1'b0, acc}, 4'd0, "R8 master ignores line_in");
    chk({3'b0, line_out}, 4'd0, "R2 master line low when idle");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_frame(2'd1, 3'b100, "sync");
    t_frame(2'd2, 3'b010, "delete");
    t_frame(2'd3, 3'b001, "insert");
    t_priority();
    t_pending();
    t_slave();
    step();
    finish_run();
  end
endmodule